// File: doc/BRIEF.md
# Floating-Point Widening Converter to 80-bit Extended Format

This unit accepts one floating-point operand per cycle, tagged as 32-bit single, 64-bit double or 80-bit extended precision. It returns the same value in the 80-bit extended layout, where the integer bit of the significand is explicit. Widening never loses information, so the unit does no rounding. Its output is meant to be written straight into an entry of a floating-point register stack by the logic around it.

Two exception indications come out with the value. One reports a signaling NaN source. The other reports a denormal (subnormal) source. Both can fire only for single and double operands. An extended operand is copied through bit for bit and never raises either one. Narrow denormals are normalized on the way, because the wider exponent range holds them as ordinary normal numbers.

The conversion logic is combinational. One register stage at the output gives a fixed latency of one clock.

Top module: `fp_widen_x80`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `result`, `flag_invalid` and `flag_denorm` are all cleared to zero on that edge, whatever the other inputs are.
- R2: When `in_valid` is high at a rising edge, the converted value and its flags appear on the outputs after that edge, and `out_valid` is high. When `in_valid` is low at an edge, `out_valid` goes low and `result` and the flags keep their previous values.
- R3: `fmt` selects the source format as follows. 2'b00 is single, taken from `operand[31:0]`. 2'b01 is double, taken from `operand[63:0]`. 2'b10 and 2'b11 are both extended, taken from all 80 bits. For narrow formats, the operand bits above the selected field have no effect.
- R4: The result layout is bit 79 sign, bits 78:64 a biased exponent (bias 16383), bit 63 the explicit integer bit, and bits 62:0 the fraction. A normal narrow source gets the exponent `e - bias_src + 16383`, with `bias_src` = 127 for single and 1023 for double. The integer bit is set, and the source fraction is left-aligned so that its MSB lands on bit 62, with zeros filled below.
- R5: A narrow source with exponent 0 and a nonzero fraction is normalized. The significand is shifted left until its leading one reaches bit 63. The exponent becomes `16383 - bias_src - lz`, where `lz` is the number of leading zeros in the source fraction. `flag_denorm` is set.
- R6: A narrow signed zero becomes exponent 0 and significand 0, and its sign is kept.
- R7: A narrow infinity becomes exponent 0x7FFF and significand 0x8000_0000_0000_0000, and its sign is kept.
- R8: A narrow NaN becomes exponent 0x7FFF, with bits 63 and 62 set and the rest of the payload left-aligned as in R4. `flag_invalid` is set exactly when the source fraction MSB is 0, which marks a signaling NaN.
- R9: An extended source is passed through unchanged, including NaN and denormal encodings, and both flags stay 0.
- R10: `flag_invalid` and `flag_denorm` are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| fmt | input | 2 | Source format: 00 single, 01 double, 1x extended |
| operand | input | 80 | Source operand, narrow formats right-aligned |
| out_valid | output | 1 | Result registered from a valid operand |
| result | output | 80 | Value in 80-bit extended format |
| flag_invalid | output | 1 | Narrow source was a signaling NaN |
| flag_denorm | output | 1 | Narrow source was denormal |

## Verification
The only state in the block is its output register, so any fault in the conversion shows up at the ports on the very next clock. A broken leading-zero count or shift appears as a wrong exponent or a misplaced leading one for a denormal input. A wrong path select appears as flags raised on extended operands, or as upper operand bits leaking into a narrow result. A register that fails to hold shows up as a changed `result` one clock after an idle cycle. The single-precision sweep covers every exponent value against every single-bit fraction, so each shift amount and each special-value class is seen at least once.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int XEXP_W = 15;
  localparam int XMAN_W = 64;
  localparam int XWIDTH = 1 + XEXP_W + XMAN_W;
  localparam int XBIAS  = 16383;

  typedef enum logic [1:0] {
    SRC_SGL  = 2'b00,
    SRC_DBL  = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_EXT2 = 2'b11
  } src_fmt_e;

  typedef struct packed {
    logic              sign;
    logic [XEXP_W-1:0] exp;
    logic [XMAN_W-1:0] man;
  } xfloat_t;
endpackage

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
  parameter int W = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpw_narrow.sv
module fpw_narrow
  import fpw_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
  localparam int PAD   = XMAN_W - 1 - FRAC_W,
  localparam int CW    = $clog2(FRAC_W + 1)
) (
  input  logic [OP_W-1:0] op,
  output xfloat_t         xv,
  output logic            is_snan,
  output logic            is_denorm
);
  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_zero, ex_ones, fr_zero;
  logic [CW-1:0]     lead;
  logic [6:0]        shamt;
  logic [XMAN_W-1:0] aligned, den_man;
  logic [15:0]       den_exp, nrm_exp;

  assign sgn     = op[OP_W-1];
  assign ex      = op[FRAC_W +: EXP_W];
  assign fr      = op[FRAC_W-1:0];
  assign ex_zero = (ex == '0);
  assign ex_ones = &ex;
  assign fr_zero = (fr == '0);

  fpw_lzc #(.W(FRAC_W)) u_lzc (.vec(fr), .zeros(lead));

  assign aligned = {1'b0, fr, {PAD{1'b0}}};
  assign shamt   = 7'(lead) + 7'd1;
  assign den_man = aligned << shamt;
  assign den_exp = 16'(XBIAS - BIAS) - 16'(lead);
  assign nrm_exp = 16'(ex) + 16'(XBIAS - BIAS);

  always_comb begin
    xv.sign   = sgn;
    is_snan   = 1'b0;
    is_denorm = 1'b0;
    if (ex_zero && fr_zero) begin
      xv.exp = '0;
      xv.man = '0;
    end else if (ex_zero) begin
      xv.exp    = den_exp[XEXP_W-1:0];
      xv.man    = den_man;
      is_denorm = 1'b1;
    end else if (ex_ones && fr_zero) begin
      xv.exp = '1;
      xv.man = {1'b1, {(XMAN_W-1){1'b0}}};
    end else if (ex_ones) begin
      xv.exp  = '1;
      xv.man  = aligned | {2'b11, {(XMAN_W-2){1'b0}}};
      is_snan = ~fr[FRAC_W-1];
    end else begin
      xv.exp = nrm_exp[XEXP_W-1:0];
      xv.man = aligned | {1'b1, {(XMAN_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/fp_widen_x80.sv
module fp_widen_x80
  import fpw_pkg::*;
#(
  parameter int SGL_EXP_W  = 8,
  parameter int SGL_FRAC_W = 23,
  parameter int DBL_EXP_W  = 11,
  parameter int DBL_FRAC_W = 52,
  localparam int NFMT      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        fmt,
  input  logic [XWIDTH-1:0] operand,
  output logic              out_valid,
  output logic [XWIDTH-1:0] result,
  output logic              flag_invalid,
  output logic              flag_denorm
);
  xfloat_t        nx_val [NFMT];
  logic [NFMT-1:0] nx_snan, nx_den;

  for (genvar g = 0; g < NFMT; g++) begin : g_narrow
    localparam int EW = (g == 0) ? SGL_EXP_W : DBL_EXP_W;
    localparam int FW = (g == 0) ? SGL_FRAC_W : DBL_FRAC_W;
    fpw_narrow #(.EXP_W(EW), .FRAC_W(FW)) u_cvt (
      .op       (operand[EW+FW:0]),
      .xv       (nx_val[g]),
      .is_snan  (nx_snan[g]),
      .is_denorm(nx_den[g])
    );
  end

  logic [XWIDTH-1:0] sel_val;
  logic              sel_inv, sel_den;

  always_comb begin
    unique case (src_fmt_e'(fmt))
      SRC_SGL: begin
        sel_val = nx_val[0];
        sel_inv = nx_snan[0];
        sel_den = nx_den[0];
      end
      SRC_DBL: begin
        sel_val = nx_val[1];
        sel_inv = nx_snan[1];
        sel_den = nx_den[1];
      end
      default: begin
        sel_val = operand;
        sel_inv = 1'b0;
        sel_den = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_denorm  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= sel_val;
        flag_invalid <= sel_inv;
        flag_denorm  <= sel_den;
      end
    end
  end
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [1:0]  fmt,
  input logic [79:0] operand,
  input logic        out_valid,
  input logic [79:0] result,
  input logic        flag_invalid,
  input logic        flag_denorm
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_invalid) && $stable(flag_denorm)));

  assert_ext_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt[1]) |=> (result == $past(operand) && !flag_invalid && !flag_denorm));

  // R4/R5/R6: for narrow sources the integer bit is set exactly when the exponent is nonzero
  assert_int_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fmt[1]) |=> ((result[78:64] != 15'd0) == result[63]));

  assert_snan_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    flag_invalid |-> (result[78:64] == 15'h7FFF && result[63] && result[62]));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(flag_invalid && flag_denorm));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && result == 80'd0 && !flag_invalid && !flag_denorm));
endmodule

bind fp_widen_x80 fpw_checker u_fpw_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .fmt         (fmt),
  .operand     (operand),
  .out_valid   (out_valid),
  .result      (result),
  .flag_invalid(flag_invalid),
  .flag_denorm (flag_denorm)
);

// File: tb/tb_fp_widen_x80.sv
module tb_fp_widen_x80;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [79:0] operand = '0;
  logic        out_valid, flag_invalid, flag_denorm;
  logic [79:0] result;

  int n_chk = 0;
  int n_fail = 0;

  fp_widen_x80 dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt), .operand(operand),
    .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
  );

  always #10 clk = ~clk;

  function automatic void ref_widen(input logic [1:0] f, input logic [79:0] op,
                                    output logic [79:0] r, output logic inv,
                                    output logic den, output string tag);
    int fw, ew, bias, x;
    logic [63:0] raw, frac, m;
    longint e;
    logic s;
    inv = 1'b0;
    den = 1'b0;
    if (f[1]) begin
      r = op;
      tag = (f == 2'b11) ? "R3/R9" : "R9";
      return;
    end
    fw   = f[0] ? 52 : 23;
    ew   = f[0] ? 11 : 8;
    raw  = f[0] ? op[63:0] : {32'd0, op[31:0]};
    frac = raw & ((64'd1 << fw) - 64'd1);
    e    = longint'((raw >> fw) & ((64'd1 << ew) - 64'd1));
    s    = raw[fw+ew];
    bias = (1 << (ew - 1)) - 1;
    m    = frac << (63 - fw);
    if (e == 0 && frac == 0) begin
      r = {s, 15'd0, 64'd0}; tag = "R3/R6";
    end else if (e == 0) begin
      x = 16383 - bias + 1;
      while (!m[63]) begin m = m << 1; x--; end
      r = {s, 15'(x), m}; den = 1'b1; tag = "R3/R5";
    end else if (e == longint'((1 << ew) - 1) && frac == 0) begin
      r = {s, 15'h7FFF, 64'h8000_0000_0000_0000}; tag = "R3/R7";
    end else if (e == longint'((1 << ew) - 1)) begin
      inv = ~m[62];
      r = {s, 15'h7FFF, m | 64'hC000_0000_0000_0000}; tag = "R3/R8";
    end else begin
      r = {s, 15'(e - longint'(bias) + 16383), m | 64'h8000_0000_0000_0000}; tag = "R3/R4";
    end
  endfunction

  task automatic apply(input logic [1:0] f, input logic [79:0] op);
    logic [79:0] er;
    logic ei, ed;
    string tag;
    ref_widen(f, op, er, ei, ed, tag);
    @(negedge clk);
    in_valid = 1'b1; fmt = f; operand = op;
    @(negedge clk);
    in_valid = 1'b0;
    n_chk++;
    if (!out_valid || result !== er || flag_invalid !== ei || flag_denorm !== ed
        || (flag_invalid && flag_denorm)) begin
      n_fail++;
      $display("FAIL %s/R2/R10 fmt=%b op=%h: act v=%b r=%h inv=%b den=%b exp v=1 r=%h inv=%b den=%b",
               tag, f, op, out_valid, result, flag_invalid, flag_denorm, er, ei, ed);
    end
  endtask

  initial begin
    repeat (50000 * 4) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [79:0] held;
    // R1: reset dominates an active input
    in_valid = 1'b1; fmt = 2'b10; operand = {80{1'b1}};
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || result !== 80'd0 || flag_invalid !== 1'b0 || flag_denorm !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 act v=%b r=%h inv=%b den=%b exp all zero", out_valid, result, flag_invalid, flag_denorm);
    end
    rst = 1'b0; in_valid = 1'b0;

    // single: every exponent against every single-bit fraction and edge fractions
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 26; k++) begin
        logic [22:0] fr;
        logic [47:0] junk;
        if (k < 23) fr = 23'd1 << k;
        else if (k == 23) fr = 23'd0;
        else if (k == 24) fr = '1;
        else fr = 23'h2A_AAAA ^ 23'(e);
        junk = {8'(e), 8'(k), 32'hDEAD_BEEF};
        apply(2'b00, {junk, 1'((e + k) & 1), 8'(e), fr});
      end
    end

    // double: exponent corners against every single-bit fraction and edge fractions
    begin
      int ex_list [9] = '{0, 1, 2, 100, 1022, 1023, 1024, 2046, 2047};
      for (int i = 0; i < 9; i++) begin
        for (int k = 0; k < 55; k++) begin
          logic [51:0] fr;
          if (k < 52) fr = 52'd1 << k;
          else if (k == 52) fr = 52'd0;
          else if (k == 53) fr = '1;
          else fr = 52'h5_5555_5555_5555;
          apply(2'b01, {16'hA5C3 ^ 16'(k), 1'((i + k) & 1), 11'(ex_list[i]), fr});
        end
      end
    end

    // R9: extended patterns, including ones a narrow path would flag
    apply(2'b10, {1'b0, 15'h0000, 64'h0000_0000_0000_0001});
    apply(2'b10, {1'b1, 15'h7FFF, 64'h8000_0000_0000_0001});
    apply(2'b10, {1'b0, 15'h7FFF, 64'hC123_4567_89AB_CDEF});
    apply(2'b10, {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000});
    apply(2'b10, {1'b1, 15'h0000, 64'h0000_0000_0000_0000});
    apply(2'b11, {1'b0, 15'h0001, 64'h0000_FFFF_0000_FFFF});
    apply(2'b11, {1'b1, 15'h7FFF, 64'h0000_0000_0000_0000});
    apply(2'b11, {80{1'b1}});

    // R2: idle cycle holds result and drops out_valid
    apply(2'b00, {48'd0, 32'h3F80_0000});
    held = result;
    @(negedge clk);
    in_valid = 1'b0; fmt = 2'b01; operand = {80{1'b1}};
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || result !== held) begin
      n_fail++;
      $display("FAIL R2 idle act v=%b r=%h exp v=0 r=%h", out_valid, result, held);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule